// File: doc/BRIEF.md
# Ethernet transmit status collector

This block follows one frame through its transmit attempts on a half- or full-duplex 10/100 CSMA/CD MAC. When the frame finishes or is aborted, it produces the status word that goes back into the transmit descriptor. It counts collisions across retries and measures a late-collision window in bit-time ticks. It also records carrier dropouts, deferral and FIFO underflow. In half duplex it waits a bounded number of bit times after frame end for the collision-line heartbeat (SQE) pulse. The finished word appears on `stat_o` together with a one-cycle `stat_valid_o` strobe.

The surrounding MAC supplies the strobes. A frame-start pulse begins a frame and clears all per-frame state. `tx_active_i` is high while bits are on the wire, and each rise of it after a collision marks a retry. A frame-end pulse marks successful completion of the attempt. Backoff, serialization, CRC and descriptor handling are done elsewhere.

Top module: `eth_tx_status`

## Requirements
- R1: After reset `stat_valid_o` is 0 and `stat_o` is all zeros.
- R2: A frame with no collision, no dropout, no deferral and an SQE pulse after its end gives status 0x0001 (bit 0 = good). `stat_valid_o` is high for exactly one cycle.
- R3: A frame that sees exactly one collision and then completes sets bit 10 and bit 0.
- R4: A frame that sees two or more collisions and then completes sets bit 9 and bit 0. Bit 10 stays clear.
- R5: With retry limit L, collisions 1..L are retried with no status. Collision L+1 aborts the frame with bit 8 set and bit 0 clear, and the status appears in the cycle after that collision is sampled.
- R6: Each attempt has a window counter of bit ticks that restarts at frame start and at every retry. A collision sampled when the counter is 511 or less is an ordinary retried collision. A collision sampled when it is 512 (LATE_WIN) or more aborts at once with bit 7 set and bit 0 clear.
- R7: CRS low for any cycle while the frame is being sent sets bit 6. Bit 0 is still set if the frame completes.
- R8: In half duplex, if no collision-line pulse arrives within SQE_WIN bit ticks after frame end, bit 5 is set and bit 0 is still set. The status appears only after that window expires.
- R9: A FIFO underflow during sending aborts the frame at once with bit 4 set and bit 0 clear.
- R10: Deferral seen at frame start or during the frame sets bit 11 in half duplex only.
- R11: In full duplex, collisions, CRS and the SQE check are ignored, so bits 11 to 5 stay 0. The status appears in the cycle after frame end.
- R12: Bits 3 to 1 and all bits above 11 are always 0. No condition from one frame appears in the status of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_start_i | input | 1 | Frame start pulse; clears per-frame state |
| tx_active_i | input | 1 | High while an attempt is on the wire; a rise after a collision starts a retry |
| tx_end_i | input | 1 | Successful end of the current attempt |
| bit_tick_i | input | 1 | One pulse per bit time |
| col_i | input | 1 | Collision line |
| crs_i | input | 1 | Carrier sense |
| underflow_i | input | 1 | Transmit FIFO underflow pulse |
| defer_i | input | 1 | Deferral indication |
| full_duplex_i | input | 1 | 1 = full duplex |
| retry_limit_i | input | RETRY_W | Number of retried collisions allowed |
| stat_o | output | STAT_W | Status word |
| stat_valid_o | output | 1 | One-cycle strobe qualifying `stat_o` |

## Verification
The assertions assume three things about the inputs. First, `full_duplex_i` does not change during a frame. Second, collision pulses are separated so that each one is a distinct rising edge. Third, a new frame start never arrives in or right after the cycle that carries the status strobe. The bench keeps to these rules in the following ways. It changes the duplex bit only between frames, when the block is idle. It drives each collision as a single-cycle pulse followed by a gap of several cycles. It waits at least two idle cycles after every status strobe before it starts the next frame.

// File: rtl/eth_txs_pkg.sv
package eth_txs_pkg;

  // status bit positions decoded by the descriptor writer
  localparam int unsigned B_GOOD  = 0;
  localparam int unsigned B_UNDF  = 4;
  localparam int unsigned B_SQE   = 5;
  localparam int unsigned B_CARR  = 6;
  localparam int unsigned B_LATE  = 7;
  localparam int unsigned B_EXCOL = 8;
  localparam int unsigned B_MCOL  = 9;
  localparam int unsigned B_SCOL  = 10;
  localparam int unsigned B_DEFER = 11;
  localparam int unsigned B_TOP   = 11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEND,
    ST_BACKOFF,
    ST_SQE
  } txs_state_e;

  typedef struct packed {
    logic defer;
    logic scol;
    logic mcol;
    logic excol;
    logic late;
    logic carr;
    logic sqe;
    logic undf;
    logic good;
  } txs_flags_t;

endpackage

// File: rtl/eth_txs_tick_cnt.sv
module eth_txs_tick_cnt #(
  parameter int unsigned LIMIT = 512,
  localparam int unsigned CW = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic reached_o
);

  logic [CW-1:0] cnt_q;

  assign reached_o = (cnt_q >= CW'(LIMIT));

  // saturates at LIMIT so the compare stays valid for long frames
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (clr_i)              cnt_q <= '0;
    else if (en_i && !reached_o) cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/eth_txs_col_track.sv
module eth_txs_col_track #(
  parameter int unsigned LIM_W = 5,
  localparam int unsigned CNT_W = LIM_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             arm_i,
  input  logic             inc_i,
  input  logic             col_i,
  input  logic [LIM_W-1:0] limit_i,
  output logic             hit_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             over_o
);

  logic             col_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_nxt;

  assign hit_o   = arm_i & col_i & ~col_q;
  assign cnt_nxt = {1'b0, cnt_q} + 1'b1;
  assign over_o  = cnt_nxt > {2'b00, limit_i};
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) col_q <= 1'b0;
    else         col_q <= col_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && !(&cnt_q))  cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/eth_tx_status.sv
module eth_tx_status
  import eth_txs_pkg::*;
#(
  parameter int unsigned LATE_WIN = 512,
  parameter int unsigned SQE_WIN  = 16,
  parameter int unsigned RETRY_W  = 5,
  parameter int unsigned STAT_W   = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tx_start_i,
  input  logic               tx_active_i,
  input  logic               tx_end_i,
  input  logic               bit_tick_i,
  input  logic               col_i,
  input  logic               crs_i,
  input  logic               underflow_i,
  input  logic               defer_i,
  input  logic               full_duplex_i,
  input  logic [RETRY_W-1:0] retry_limit_i,
  output logic [STAT_W-1:0]  stat_o,
  output logic               stat_valid_o
);

  localparam int unsigned CNT_W = RETRY_W + 1;

  txs_state_e       st_q, st_d;
  logic             act_q, act_rise, half;
  logic             defer_f, carr_f;
  logic             win_late, sqe_late;
  logic             col_hit, col_over, col_inc;
  logic [CNT_W-1:0] col_cnt;
  logic             emit;
  txs_flags_t       fl;
  logic [STAT_W-1:0] stat_d, stat_q;
  logic             valid_q;

  assign half     = ~full_duplex_i;
  assign act_rise = tx_active_i & ~act_q;

  eth_txs_tick_cnt #(.LIMIT(LATE_WIN)) u_win (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (tx_start_i | ((st_q == ST_BACKOFF) & act_rise)),
    .en_i     ((st_q == ST_SEND) & bit_tick_i),
    .reached_o(win_late)
  );

  eth_txs_tick_cnt #(.LIMIT(SQE_WIN)) u_sqe (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (st_q != ST_SQE),
    .en_i     ((st_q == ST_SQE) & bit_tick_i),
    .reached_o(sqe_late)
  );

  assign col_inc = col_hit & ~win_late & ~col_over & ~underflow_i;

  eth_txs_col_track #(.LIM_W(RETRY_W)) u_col (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tx_start_i),
    .arm_i  ((st_q == ST_SEND) & half),
    .inc_i  (col_inc),
    .col_i  (col_i),
    .limit_i(retry_limit_i),
    .hit_o  (col_hit),
    .cnt_o  (col_cnt),
    .over_o (col_over)
  );

  always_comb begin
    st_d = st_q;
    emit = 1'b0;
    fl   = '0;
    unique case (st_q)
      ST_SEND: begin
        if (underflow_i) begin
          emit    = 1'b1;
          fl.undf = 1'b1;
        end else if (col_hit) begin
          if (win_late) begin
            emit    = 1'b1;
            fl.late = 1'b1;
          end else if (col_over) begin
            emit     = 1'b1;
            fl.excol = 1'b1;
          end else begin
            st_d = ST_BACKOFF;
          end
        end else if (tx_end_i) begin
          if (half) st_d = ST_SQE;
          else begin
            emit    = 1'b1;
            fl.good = 1'b1;
          end
        end
      end
      ST_BACKOFF: if (act_rise) st_d = ST_SEND;
      ST_SQE: begin
        if (col_i) begin
          emit    = 1'b1;
          fl.good = 1'b1;
        end else if (sqe_late) begin
          emit    = 1'b1;
          fl.good = 1'b1;
          fl.sqe  = 1'b1;
        end
      end
      default: ;
    endcase
    if (emit) begin
      st_d     = ST_IDLE;
      fl.scol  = fl.good & (col_cnt == CNT_W'(1));
      fl.mcol  = fl.good & (col_cnt > CNT_W'(1));
      fl.carr  = carr_f;
      fl.defer = defer_f & half;
    end
    if (tx_start_i) st_d = ST_SEND;
  end

  always_comb begin
    stat_d          = '0;
    stat_d[B_GOOD]  = fl.good;
    stat_d[B_UNDF]  = fl.undf;
    stat_d[B_SQE]   = fl.sqe;
    stat_d[B_CARR]  = fl.carr;
    stat_d[B_LATE]  = fl.late;
    stat_d[B_EXCOL] = fl.excol;
    stat_d[B_MCOL]  = fl.mcol;
    stat_d[B_SCOL]  = fl.scol;
    stat_d[B_DEFER] = fl.defer;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      act_q   <= 1'b0;
      defer_f <= 1'b0;
      carr_f  <= 1'b0;
      stat_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      act_q   <= tx_active_i;
      valid_q <= emit;
      if (emit) stat_q <= stat_d;
      if (tx_start_i) begin
        defer_f <= defer_i;
        carr_f  <= 1'b0;
      end else begin
        if (((st_q == ST_SEND) || (st_q == ST_BACKOFF)) && defer_i) defer_f <= 1'b1;
        if ((st_q == ST_SEND) && half && tx_active_i && !crs_i)    carr_f  <= 1'b1;
      end
    end
  end

  assign stat_o       = stat_q;
  assign stat_valid_o = valid_q;

endmodule

// File: rtl/eth_tx_status_chk.sv
module eth_tx_status_chk #(
  parameter int unsigned STAT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              full_duplex_i,
  input logic              win_late_i,
  input logic [STAT_W-1:0] stat_i,
  input logic              valid_i
);

  // R2: strobe lasts one cycle
  a_r2_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> !valid_i);

  // R3, R4: single and multiple collision bits exclusive
  a_r4_scol_mcol_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> !(stat_i[10] && stat_i[9]));

  // R5, R9: fatal conditions block the good bit
  a_r9_good_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && stat_i[0]) |-> !(stat_i[4] || stat_i[7] || stat_i[8]));

  // R6: late abort only once the window counter has run out
  a_r6_late_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && stat_i[7]) |-> $past(win_late_i));

  // R11: full duplex masks collision, carrier, SQE and deferral bits
  a_r11_fd_mask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(full_duplex_i)) |-> (stat_i[11:5] == '0));

  // R8: SQE check only in half duplex
  a_r8_sqe_half: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && stat_i[5]) |-> !$past(full_duplex_i));

endmodule

bind eth_tx_status eth_tx_status_chk #(.STAT_W(STAT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .full_duplex_i(full_duplex_i),
  .win_late_i   (win_late),
  .stat_i       (stat_o),
  .valid_i      (stat_valid_o)
);

// File: tb/sim_eth_tx_status.sv
module sim_eth_tx_status;

  localparam int CLK_PERIOD = 10;
  localparam int LATE_WIN   = 512;
  localparam int SQE_WIN    = 16;
  localparam int RETRY_W    = 5;
  localparam int STAT_W     = 16;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_start = 1'b0, tx_active = 1'b0, tx_end = 1'b0, tick = 1'b0;
  logic col = 1'b0, crs = 1'b1, undf = 1'b0, defer = 1'b0, fd = 1'b0;
  logic [RETRY_W-1:0] limit = 5'd15;
  logic [STAT_W-1:0]  stat_o;
  logic               stat_valid_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  eth_tx_status #(
    .LATE_WIN(LATE_WIN), .SQE_WIN(SQE_WIN), .RETRY_W(RETRY_W), .STAT_W(STAT_W)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tx_start_i(tx_start), .tx_active_i(tx_active),
    .tx_end_i(tx_end), .bit_tick_i(tick), .col_i(col), .crs_i(crs),
    .underflow_i(undf), .defer_i(defer), .full_duplex_i(fd),
    .retry_limit_i(limit), .stat_o(stat_o), .stat_valid_o(stat_valid_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // waits for the strobe from the current negedge, then checks it drops
  task automatic get_status(input string req, input int maxw,
                            output logic [STAT_W-1:0] s, output int lat);
    s = 'x;
    lat = -1;
    for (int i = 0; i < maxw; i++) begin
      if (stat_valid_o === 1'b1) begin
        s = stat_o;
        lat = i;
        break;
      end
      @(negedge clk);
    end
    check({req, " strobe seen"}, 32'(lat >= 0), 32'd1);
    @(negedge clk);
    check("R2 strobe one cycle", 32'(stat_valid_o), 32'd0);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic begin_frame(input logic dfr);
    tx_start = 1'b1; tx_active = 1'b1; crs = 1'b1; defer = dfr;
    @(negedge clk);
    tx_start = 1'b0; defer = 1'b0;
  endtask

  task automatic run_ticks(input int n);
    if (n > 0) begin
      tick = 1'b1;
      repeat (n) @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic hit_col();
    col = 1'b1;
    @(negedge clk);
    col = 1'b0;
  endtask

  task automatic re_attempt();
    tx_active = 1'b0;
    idle(3);
    tx_active = 1'b1;
    @(negedge clk);
  endtask

  task automatic end_frame();
    tx_end = 1'b1;
    @(negedge clk);
    tx_end = 1'b0; tx_active = 1'b0;
  endtask

  task automatic sqe_pulse();
    @(negedge clk);
    hit_col();
  endtask

  task automatic t_clean(input string req);
    logic [STAT_W-1:0] s; int lat;
    begin_frame(1'b0); run_ticks(100); end_frame(); sqe_pulse();
    get_status(req, 4, s, lat);
    check({req, " clean frame status"}, 32'(s), 32'h0001);
    idle(2);
  endtask

  task automatic t_one_col();
    logic [STAT_W-1:0] s; int lat;
    begin_frame(1'b0); run_ticks(60); hit_col();
    check("R3 no status on retried collision", 32'(stat_valid_o), 32'd0);
    re_attempt(); run_ticks(100); end_frame(); sqe_pulse();
    get_status("R3", 4, s, lat);
    check("R3 single collision status", 32'(s), 32'h0401);
    idle(2);
  endtask

  task automatic t_three_col();
    logic [STAT_W-1:0] s; int lat;
    begin_frame(1'b0);
    run_ticks(300); hit_col(); re_attempt();
    run_ticks(300); hit_col(); re_attempt();
    run_ticks(50);  hit_col(); re_attempt();
    run_ticks(400); end_frame(); sqe_pulse();
    get_status("R4", 4, s, lat);
    check("R4 R6 three collisions, window restarts", 32'(s), 32'h0201);
    idle(2);
  endtask

  task automatic t_excol();
    logic [STAT_W-1:0] s; int lat;
    limit = 5'd2;
    begin_frame(1'b0);
    run_ticks(10); hit_col(); re_attempt();
    run_ticks(10); hit_col();
    check("R5 collision at limit retried", 32'(stat_valid_o), 32'd0);
    re_attempt();
    run_ticks(10); hit_col();
    get_status("R5", 1, s, lat);
    check("R5 excessive collision status", 32'(s), 32'h0100);
    check("R5 abort latency", 32'(lat), 32'd0);
    tx_active = 1'b0; limit = 5'd15;
    idle(2);
  endtask

  task automatic t_win511();
    logic [STAT_W-1:0] s; int lat;
    begin_frame(1'b0); run_ticks(LATE_WIN - 1); hit_col();
    check("R6 collision at 511 not late", 32'(stat_valid_o), 32'd0);
    re_attempt(); run_ticks(20); end_frame(); sqe_pulse();
    get_status("R6", 4, s, lat);
    check("R6 collision at 511 retried", 32'(s), 32'h0401);
    idle(2);
  endtask

  task automatic t_win512();
    logic [STAT_W-1:0] s; int lat;
    begin_frame(1'b0); run_ticks(LATE_WIN); hit_col();
    get_status("R6", 1, s, lat);
    check("R6 collision at 512 late abort", 32'(s), 32'h0080);
    tx_active = 1'b0;
    idle(2);
  endtask

  task automatic t_crs();
    logic [STAT_W-1:0] s; int lat;
    begin_frame(1'b0); run_ticks(30);
    crs = 1'b0; @(negedge clk); crs = 1'b1;
    run_ticks(30); end_frame(); sqe_pulse();
    get_status("R7", 4, s, lat);
    check("R7 carrier loss status", 32'(s), 32'h0041);
    idle(2);
  endtask

  task automatic t_sqe_miss();
    logic [STAT_W-1:0] s; int lat;
    begin_frame(1'b0); run_ticks(40); end_frame();
    tick = 1'b1;
    get_status("R8", SQE_WIN + 10, s, lat);
    tick = 1'b0;
    check("R8 missing SQE status", 32'(s), 32'h0021);
    check("R8 status held until window ends", 32'(lat >= SQE_WIN), 32'd1);
    idle(2);
  endtask

  task automatic t_undf();
    logic [STAT_W-1:0] s; int lat;
    begin_frame(1'b0); run_ticks(50);
    undf = 1'b1; @(negedge clk); undf = 1'b0;
    get_status("R9", 1, s, lat);
    check("R9 underflow abort status", 32'(s), 32'h0010);
    tx_active = 1'b0;
    idle(2);
  endtask

  task automatic t_defer();
    logic [STAT_W-1:0] s; int lat;
    begin_frame(1'b1); run_ticks(20); end_frame(); sqe_pulse();
    get_status("R10", 4, s, lat);
    check("R10 deferred in half duplex", 32'(s), 32'h0801);
    idle(2);
  endtask

  task automatic t_full_duplex();
    logic [STAT_W-1:0] s; int lat;
    fd = 1'b1;
    idle(1);
    begin_frame(1'b1); run_ticks(LATE_WIN + 20); hit_col();
    check("R11 collision ignored", 32'(stat_valid_o), 32'd0);
    crs = 1'b0; @(negedge clk); crs = 1'b1;
    run_ticks(10); end_frame();
    get_status("R11", 1, s, lat);
    check("R11 R10 full duplex masks status", 32'(s), 32'h0001);
    check("R11 no SQE wait", 32'(lat), 32'd0);
    idle(2);
    fd = 1'b0;
    idle(1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end

  initial begin
    idle(3);
    check("R1 reset valid", 32'(stat_valid_o), 32'd0);
    check("R1 reset status", 32'(stat_o), 32'd0);
    rst_ni = 1'b1;
    idle(2);
    t_clean("R2");
    t_one_col();
    t_three_col();
    t_excol();
    t_win511();
    t_win512();
    t_clean("R12 after late abort");
    t_crs();
    t_sqe_miss();
    t_undf();
    t_clean("R12 after underflow");
    t_defer();
    t_full_duplex();
    t_clean("R12 back in half duplex");
    summary();
  end

endmodule